// File: doc/BRIEF.md
# Ring-Passed Output Permission Arbiter

Several encoder units each produce a share of one compressed stream, and all of them drive a single shared byte bus. Each unit keeps its share as a queue of bytes, and every byte carries a one-bit end-of-field mark. A field is a run of bytes that must appear unbroken in the final stream. Only one unit at a time holds the right to drive the bus. That unit sends bytes from its queue. When it sends a byte whose end-of-field mark is set, it gives up the right and pulses a single token wire to the unit that follows it in a fixed ring. The stream on the shared bus is therefore the fields of all units taken in ring order.

One copy of this block sits in every unit. The logic is the same whatever the ring size. A parameter selects the copy that holds the right out of reset. A second parameter selects how a unit without the right presents its data: forced to zero, for a wired-OR bus, or passed through, for a bus multiplexed by the outer fabric on the valid line.

Top module: `tokring_out_arb`

## Requirements
- R1: After reset, only the instance with START_HOLDER=1 holds the permission. No instance asserts out_valid or tok_out until bytes are queued.
- R2: out_valid is high only while the instance holds the permission and its queue is non-empty. Bytes leave in the order they were accepted, each with its own end-of-field mark.
- R3: In the cycle the holder presents a byte with out_last=1, tok_out is high for exactly that one cycle. From the next cycle the instance no longer holds the permission.
- R4: A one-cycle pulse on tok_in gives the instance the permission from the next cycle. A successor can therefore send in the cycle right after its predecessor's last byte.
- R5: A holder whose queue is empty keeps the permission and drives nothing until its end-of-field byte has been sent.
- R6: In a ring of instances, at most one out_valid is high in any cycle.
- R7: With BUS_MODE=BUS_OR, out_data and out_last are all zero whenever out_valid is low.
- R8: in_ready is high exactly when the queue has a free slot (DEPTH entries). A byte is accepted on a clock edge where in_valid and in_ready are both high.
- R9: In a ring, the shared stream carries field 0 of every unit in ring order starting at the initial holder, then field 1 of every unit, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | DATA_W | Producer byte |
| in_last | input | 1 | Byte ends a field |
| in_ready | output | 1 | Queue has a free slot |
| tok_in | input | 1 | Token pulse from the predecessor |
| tok_out | output | 1 | Token pulse to the successor |
| out_valid | output | 1 | This instance drives a byte this cycle |
| out_data | output | DATA_W | Byte for the shared bus |
| out_last | output | 1 | End-of-field mark of the byte on the bus |

## Verification
The assertions assume a ring of at least two instances. In such a ring a token never reaches a unit that already holds the permission, and exactly one instance starts as holder. The bench wires three instances in a ring with a single initial holder and ORs their buses together. Producers push only when in_ready was seen high, so no byte is offered to a full queue. The first holder's producer starts late and the other producers have gaps in their pacing, so holders stall on empty queues while their neighbours already have data waiting.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
   typedef enum logic [0:0] {
      BUS_MUX = 1'b0,
      BUS_OR  = 1'b1
   } bus_mode_e;
endpackage

// File: rtl/tokring_fifo.sv
module tokring_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_last,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              head_last,
   output logic              empty,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);
   localparam int EW = DATA_W + 1;

   logic [EW-1:0] mem [DEPTH];
   logic [AW:0]   wr_q, rd_q;

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("tokring_fifo: DEPTH must be a power of two >= 2");
      if (DATA_W < 1)
         $error("tokring_fifo: DATA_W must be >= 1");
   end

   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
   assign {head_last, head_data} = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wr_q[AW-1:0]] <= {push_last, push_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end
endmodule

// File: rtl/tokring_permit.sv
module tokring_permit #(
   parameter bit START_HOLDER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_in,
   input  logic send,
   input  logic send_last,
   output logic permit,
   output logic tok_out
);
   logic release_now;

   assign release_now = send && send_last;
   assign tok_out     = release_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) permit <= START_HOLDER;
      else        permit <= tok_in || (permit && !release_now);
   end
endmodule

// File: rtl/tokring_gate.sv
module tokring_gate #(
   parameter int                    DATA_W   = 8,
   parameter tokring_pkg::bus_mode_e BUS_MODE = tokring_pkg::BUS_OR
) (
   input  logic              drive,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_last,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_last
);
   generate
      if (BUS_MODE == tokring_pkg::BUS_OR) begin : g_or
         assign bus_data = src_data & {DATA_W{drive}};
         assign bus_last = src_last & drive;
      end else begin : g_mux
         assign bus_data = src_data;
         assign bus_last = src_last;
      end
   endgenerate
endmodule

// File: rtl/tokring_out_arb.sv
module tokring_out_arb #(
   parameter int                     DATA_W       = 8,
   parameter int                     DEPTH        = 16,
   parameter bit                     START_HOLDER = 1'b0,
   parameter tokring_pkg::bus_mode_e BUS_MODE     = tokring_pkg::BUS_OR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              tok_in,
   output logic              tok_out,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   logic              q_empty, q_full, permit_q, send;
   logic [DATA_W-1:0] head_data;
   logic              head_last;

   assign in_ready  = !q_full;
   assign send      = permit_q && !q_empty;
   assign out_valid = send;

   tokring_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid && !q_full), .push_data(in_data), .push_last(in_last),
      .pop(send), .head_data(head_data), .head_last(head_last),
      .empty(q_empty), .full(q_full)
   );

   tokring_permit #(.START_HOLDER(START_HOLDER)) u_permit (
      .clk(clk), .rst_n(rst_n), .tok_in(tok_in),
      .send(send), .send_last(head_last),
      .permit(permit_q), .tok_out(tok_out)
   );

   tokring_gate #(.DATA_W(DATA_W), .BUS_MODE(BUS_MODE)) u_gate (
      .drive(send), .src_data(head_data), .src_last(head_last),
      .bus_data(out_data), .bus_last(out_last)
   );
endmodule

// File: rtl/tokring_out_arb_chk.sv
module tokring_out_arb_chk #(
   parameter int DATA_W  = 8,
   parameter bit OR_MODE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tok_in,
   input logic              tok_out,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              permit
);
   AST_TOK_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |-> (out_valid && out_last)); // R3
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out && !tok_in |=> !permit); // R3
   AST_VALID_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> permit); // R2
   AST_TOK_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
      tok_in |=> permit); // R4
   AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      permit && !out_valid |=> permit); // R5
   AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      tok_in |-> !permit); // R6
   generate
      if (OR_MODE) begin : g_or
         AST_OR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> (out_data == '0 && !out_last)); // R7
      end
   endgenerate
endmodule

bind tokring_out_arb tokring_out_arb_chk #(
   .DATA_W(DATA_W),
   .OR_MODE(BUS_MODE == tokring_pkg::BUS_OR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_out(tok_out),
   .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
   .permit(permit_q)
);

// File: tb/sim_tokring_out_arb.sv
`timescale 1ns/1ps
module sim_tokring_out_arb;
   localparam int N      = 3;
   localparam int NF     = 6;
   localparam int DW     = 8;
   localparam int DEPTH  = 4;
   localparam int MAXTOT = N * NF * 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N-1:0]  in_valid, in_last, in_ready, tok_in, tok_out, out_valid, out_last;
   logic [DW-1:0] in_data  [N];
   logic [DW-1:0] out_data [N];
   logic [DW-1:0] bus_data;
   logic          bus_last;

   generate
      for (genvar i = 0; i < N; i++) begin : g_unit
         assign tok_in[i] = tok_out[(i + N - 1) % N];
         tokring_out_arb #(.DATA_W(DW), .DEPTH(DEPTH), .START_HOLDER(i == 0),
                           .BUS_MODE(tokring_pkg::BUS_OR)) u0 (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid[i]), .in_data(in_data[i]), .in_last(in_last[i]),
            .in_ready(in_ready[i]), .tok_in(tok_in[i]), .tok_out(tok_out[i]),
            .out_valid(out_valid[i]), .out_data(out_data[i]), .out_last(out_last[i])
         );
      end
   endgenerate

   always_comb begin
      bus_data = '0;
      bus_last = 1'b0;
      for (int i = 0; i < N; i++) begin
         bus_data = bus_data | out_data[i];
         bus_last = bus_last | out_last[i];
      end
   end

   int checks = 0, failures = 0;
   logic [DW-1:0] exp_d [MAXTOT];
   logic          exp_l [MAXTOT];
   int total = 0;

   function automatic int flen(int u, int f);
      return 1 + ((u + 2 * f) % 4);
   endfunction
   function automatic logic [DW-1:0] fbyte(int u, int f, int b);
      return {u[1:0], f[2:0], b[2:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int pf [N];
   int pb [N];
   int cyc = 0;
   int k = 0;
   int holder = 0;
   bit done = 0;

   initial begin
      for (int f = 0; f < NF; f++)
         for (int u = 0; u < N; u++)
            for (int b = 0; b < flen(u, f); b++) begin
               exp_d[total] = fbyte(u, f, b);
               exp_l[total] = (b == flen(u, f) - 1);
               total++;
            end
      in_valid = '0; in_last = '0;
      for (int u = 0; u < N; u++) begin in_data[u] = '0; pf[u] = 0; pb[u] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
      chk(tok_out == '0, "R1 tok_out after reset", int'(tok_out), 0);
      chk(in_ready == '1, "R8 in_ready with empty queue", int'(in_ready), 7);
      while (!done && cyc < 5000) begin
         // observe outputs for the coming edge
         chk($countones(out_valid) <= 1, "R6 single driver", $countones(out_valid), 1);
         if (out_valid == '0) begin
            chk(bus_data == '0 && !bus_last, "R7 idle bus zero", int'(bus_data), 0);
         end else begin
            chk(out_valid[holder], "R4 driver is token holder", int'(out_valid), 1 << holder);
            if (cyc < 21) chk(1'b0, "R5 output before first holder fed", cyc, 21);
            chk(bus_data == exp_d[k] && bus_last == exp_l[k], "R9 R2 stream byte",
                int'({bus_last, bus_data}), int'({exp_l[k], exp_d[k]}));
            chk(tok_out == (bus_last ? (N'(1) << holder) : '0), "R3 token pulse",
                int'(tok_out), bus_last ? (1 << holder) : 0);
            if (bus_last) holder = (holder + 1) % N;
            k++;
            if (k == total) done = 1;
         end
         // drive producers for the coming edge
         for (int u = 0; u < N; u++) begin
            bit pace;
            pace = (u == 0) ? (cyc >= 20 && (cyc % 5) != 0) : ((cyc % (u + 2)) != 0);
            if (pf[u] < NF && pace && in_ready[u]) begin
               in_valid[u] = 1'b1;
               in_data[u]  = fbyte(u, pf[u], pb[u]);
               in_last[u]  = (pb[u] == flen(u, pf[u]) - 1);
               if (in_last[u]) begin pb[u] = 0; pf[u]++; end
               else pb[u]++;
            end else begin
               in_valid[u] = 1'b0;
               in_last[u]  = 1'b0;
            end
         end
         @(negedge clk);
         cyc++;
      end
      in_valid = '0;
      if (!done) chk(1'b0, "R9 watchdog expired", k, total);
      chk(k == total, "R9 byte count", k, total);
      repeat (2) @(negedge clk);
      chk(out_valid == '0, "R2 quiet after drain", int'(out_valid), 0);
      chk(holder == 0, "R9 token back at first unit", holder, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule